// File: doc/BRIEF.md
# Write-Once Memory Map Configuration Register

This block is an 8-bit configuration register placed on the CPU register bus. Its upper nibble sets which 4 KB page holds a 768-byte EEPROM window. In that page the window covers offsets 0xD00 to 0xFFF. While the part runs in a normal operating mode, the nibble accepts only the first write after reset. In special modes the nibble stays freely writable.

The lower bits are writable at any time. Bit 3 selects the stretch policy for external bus cycles. Bits 1:0 select a receive-start delay of one to four sixteenth-slot ticks. Bit 2 does not exist.

From the register contents and the current CPU address, the block produces three things:
- an EEPROM chip-select;
- a one-E-cycle stretch request for external accesses;
- the delay code and its tick count.

A small timer uses the delay code: a start pulse arms it, and it raises a one-cycle done strobe after the selected number of ticks.

Top module: `memmap_cfg_reg`

## Requirements
- R1: After synchronous reset, `reg_rdata` is 0x00, `dly_done` is 0 and `dly_ticks` is 1.
- R2: In normal mode (`special_mode`=0), the first write after reset loads bits 7:4. Every later normal-mode write leaves bits 7:4 unchanged.
- R3: Every write loads bits 3, 1 and 0 from `reg_wdata`, whatever the mode and the lock state. A write updates `reg_rdata` in the cycle after the clock edge that samples `reg_wr`.
- R4: Bit 2 of `reg_rdata` always reads 0, including after a write of 1 to that bit.
- R5: With `special_mode`=1, a write always loads bits 7:4. Such a write does not arm the lock, so the next normal-mode write still loads bits 7:4.
- R6: Let N be bits 7:4. `ee_sel` is 1 exactly when `cpu_addr` lies in N*0x1000+0xD00 through N*0x1000+0xFFF inclusive. The decode is combinational.
- R7: When bit 3 is 1, `stretch_req` is 1 for every external access (`ext_access`=1) that is outside the EEPROM window.
- R8: When bit 3 is 0 and `rom_at_low`=1, only external accesses in 0x0000–0x1FFF request a stretch.
- R9: When bit 3 is 0 and `rom_at_low`=0, only external accesses in 0xC000–0xDFFF request a stretch.
- R10: `stretch_req` is 0 whenever `ext_access` is 0 or `ee_sel` is 1.
- R11: `dly_ticks` equals the value of bits 1:0 plus one, giving 1 to 4.
- R12: After a `dly_start` pulse, `dly_done` is 1 for exactly one cycle. That cycle follows the clock edge that samples the (code+1)-th `slot_tick`, where code is the delay code held at the start pulse. Ticks while idle produce no done.
- R13: A `dly_start` while the timer is counting restarts the count from the full value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback, bit 2 always 0 |
| special_mode | input | 1 | 1 = special mode, which disables the write-once lock |
| rom_at_low | input | 1 | 1 = ROM placed low, so 0x0000–0x1FFF is the stretched range |
| cpu_addr | input | 16 | Current CPU address |
| ext_access | input | 1 | Current access goes to the external bus |
| ee_sel | output | 1 | EEPROM window chip-select |
| stretch_req | output | 1 | Request to lengthen this access by one E cycle |
| dly_start | input | 1 | Pulse that arms the receive-start delay timer |
| slot_tick | input | 1 | Sixteenth-slot tick enable |
| dly_code | output | 2 | Delay select bits 1:0 |
| dly_ticks | output | 3 | Delay length in ticks (code+1) |
| dly_done | output | 1 | One-cycle strobe at the end of the delay |

## Verification
A wrong lock flag shows on the next normal-mode write: the readback nibble either moves when it should hold, or stays when it should load. The EEPROM select shows the same error in the same cycle, because the window is decoded from that nibble. A wrong stretch-select bit or a wrong range decode shows at once on `stretch_req` for the boundary addresses of each 8 KB range. A corrupted timer count shows as `dly_done` arriving one or more ticks early or late, or as a restart that keeps the old count.

// File: rtl/memmap_cfg_pkg.sv
package memmap_cfg_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int NIB_W    = 4;
    localparam int DLY_W    = 2;
    localparam int TICK_W   = DLY_W + 1;
    localparam int PAGE_W   = ADDR_W - NIB_W;
    localparam int REGION_W = 3;
    localparam int POS_LSB  = 4;
    localparam int STR_BIT  = 3;
    localparam int GAP_BIT  = 2;
    localparam logic [PAGE_W-1:0]   WIN_LO_OFF    = 12'hD00;
    localparam logic [REGION_W-1:0] ROM_LO_REGION = 3'd0;
    localparam logic [REGION_W-1:0] ROM_HI_REGION = 3'd6;

    typedef struct packed {
        logic [NIB_W-1:0] ee_pos;
        logic             stretch_all;
        logic [DLY_W-1:0] dly_code;
    } cfg_t;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    function automatic logic [DATA_W-1:0] pack_readback(input cfg_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[DATA_W-1:POS_LSB] = c.ee_pos;
        v[STR_BIT]          = c.stretch_all;
        v[GAP_BIT]          = 1'b0;
        v[DLY_W-1:0]        = c.dly_code;
        return v;
    endfunction

    function automatic logic [TICK_W-1:0] code_to_ticks(input logic [DLY_W-1:0] code);
        return {1'b0, code} + TICK_W'(1);
    endfunction
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import memmap_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              special,
    output cfg_t              cfg,
    output logic              locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            locked <= 1'b0;
        end else if (wr) begin
            cfg.stretch_all <= wdata[STR_BIT];
            cfg.dly_code    <= wdata[DLY_W-1:0];
            if (special || !locked)
                cfg.ee_pos <= wdata[DATA_W-1:POS_LSB];
            if (!special)
                locked <= 1'b1;
        end
    end
endmodule

// File: rtl/ee_window_dec.sv
module ee_window_dec
    import memmap_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]  page,
    output logic              sel
);
    logic page_hit;
    logic off_hit;

    always_comb begin
        page_hit = (addr[ADDR_W-1 -: NIB_W] == page);
        off_hit  = (addr[PAGE_W-1:0] >= WIN_LO_OFF);
        sel      = page_hit && off_hit;
    end
endmodule

// File: rtl/stretch_qual.sv
module stretch_qual
    import memmap_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext,
    input  logic              rom_low,
    input  logic              stretch_all,
    input  logic              in_window,
    output logic              req
);
    logic [REGION_W-1:0] region;
    logic                ranged_hit;

    always_comb begin
        region     = addr[ADDR_W-1 -: REGION_W];
        ranged_hit = rom_low ? (region == ROM_LO_REGION)
                             : (region == ROM_HI_REGION);
        req        = ext && !in_window && (stretch_all || ranged_hit);
    end
endmodule

// File: rtl/rx_delay_timer.sv
module rx_delay_timer
    import memmap_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tick,
    input  logic [DLY_W-1:0]  code,
    output logic [TICK_W-1:0] ticks,
    output logic              done
);
    tmr_state_e        state;
    logic [TICK_W-1:0] cnt;

    assign ticks = code_to_ticks(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TMR_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state <= TMR_RUN;
                cnt   <= ticks;
            end else if (state == TMR_RUN && tick) begin
                if (cnt == TICK_W'(1)) begin
                    state <= TMR_IDLE;
                    done  <= 1'b1;
                end else begin
                    cnt <= cnt - TICK_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/memmap_cfg_reg.sv
module memmap_cfg_reg
    import memmap_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              special_mode,
    input  logic              rom_at_low,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              ext_access,
    output logic              ee_sel,
    output logic              stretch_req,
    input  logic              dly_start,
    input  logic              slot_tick,
    output logic [DLY_W-1:0]  dly_code,
    output logic [TICK_W-1:0] dly_ticks,
    output logic              dly_done
);
    cfg_t cfg_q;
    logic lock_q;

    cfg_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .special (special_mode),
        .cfg     (cfg_q),
        .locked  (lock_q)
    );

    ee_window_dec u_win (
        .addr (cpu_addr),
        .page (cfg_q.ee_pos),
        .sel  (ee_sel)
    );

    stretch_qual u_str (
        .addr        (cpu_addr),
        .ext         (ext_access),
        .rom_low     (rom_at_low),
        .stretch_all (cfg_q.stretch_all),
        .in_window   (ee_sel),
        .req         (stretch_req)
    );

    rx_delay_timer u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (dly_start),
        .tick  (slot_tick),
        .code  (cfg_q.dly_code),
        .ticks (dly_ticks),
        .done  (dly_done)
    );

    assign reg_rdata = pack_readback(cfg_q);
    assign dly_code  = cfg_q.dly_code;
endmodule

// File: rtl/memmap_cfg_chk.sv
module memmap_cfg_chk
    import memmap_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              special_mode,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              ext_access,
    input logic              ee_sel,
    input logic              stretch_req,
    input logic              dly_done,
    input logic              lock_q
);
    assert_lock_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !special_mode && lock_q) |=> $stable(reg_rdata[DATA_W-1:POS_LSB]));

    assert_low_bits_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata[STR_BIT] == $past(reg_wdata[STR_BIT]))
                && (reg_rdata[DLY_W-1:0] == $past(reg_wdata[DLY_W-1:0])));

    assert_gap_zero_R4: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[GAP_BIT] == 1'b0);

    assert_special_load_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && special_mode) |=> reg_rdata[DATA_W-1:POS_LSB] == $past(reg_wdata[DATA_W-1:POS_LSB]));

    assert_window_R6: assert property (@(posedge clk) disable iff (rst)
        ee_sel |-> (cpu_addr[ADDR_W-1 -: NIB_W] == reg_rdata[DATA_W-1:POS_LSB])
                && (cpu_addr[PAGE_W-1:0] >= WIN_LO_OFF));

    assert_stretch_all_R7: assert property (@(posedge clk) disable iff (rst)
        (ext_access && !ee_sel && reg_rdata[STR_BIT]) |-> stretch_req);

    assert_no_int_stretch_R10: assert property (@(posedge clk) disable iff (rst)
        (!ext_access || ee_sel) |-> !stretch_req);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        dly_done |=> !dly_done);
endmodule

bind memmap_cfg_reg memmap_cfg_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .special_mode (special_mode),
    .cpu_addr     (cpu_addr),
    .ext_access   (ext_access),
    .ee_sel       (ee_sel),
    .stretch_req  (stretch_req),
    .dly_done     (dly_done),
    .lock_q       (lock_q)
);

// File: tb/memmap_cfg_reg_tb.sv
module memmap_cfg_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        special_mode = 1'b0;
    logic        rom_at_low = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        ext_access = 1'b0;
    logic        ee_sel;
    logic        stretch_req;
    logic        dly_start = 1'b0;
    logic        slot_tick = 1'b0;
    logic [1:0]  dly_code;
    logic [2:0]  dly_ticks;
    logic        dly_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    memmap_cfg_reg dut_i (.*);

    // vector: cfg[27:20] rom[19] ext[18] addr[17:2] sel[1] str[0]
    localparam int NV = 18;
    localparam logic [27:0] VECS [NV] = '{
        {8'h00, 1'b1, 1'b1, 16'h0D00, 1'b1, 1'b0},
        {8'h00, 1'b1, 1'b1, 16'h0CFF, 1'b0, 1'b1},
        {8'h00, 1'b1, 1'b1, 16'h2000, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b1, 16'hC000, 1'b0, 1'b1},
        {8'h00, 1'b0, 1'b1, 16'hDFFF, 1'b0, 1'b1},
        {8'h00, 1'b0, 1'b1, 16'hBFFF, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b1, 16'hE000, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b1, 16'h1000, 1'b0, 1'b0},
        {8'h08, 1'b0, 1'b1, 16'h5000, 1'b0, 1'b1},
        {8'h08, 1'b1, 1'b0, 16'h5000, 1'b0, 1'b0},
        {8'hA8, 1'b1, 1'b1, 16'hAD00, 1'b1, 1'b0},
        {8'hA8, 1'b1, 1'b1, 16'hAFFF, 1'b1, 1'b0},
        {8'hA0, 1'b0, 1'b0, 16'hACFF, 1'b0, 1'b0},
        {8'hA0, 1'b0, 1'b1, 16'hBD00, 1'b0, 1'b0},
        {8'hF0, 1'b0, 1'b1, 16'hFFFF, 1'b1, 1'b0},
        {8'hC0, 1'b0, 1'b1, 16'hCD80, 1'b1, 1'b0},
        {8'hC0, 1'b0, 1'b1, 16'hCC00, 1'b0, 1'b1},
        {8'h0C, 1'b1, 1'b1, 16'h8000, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] d, input logic spec);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        special_mode = spec;
        @(negedge clk);
        reg_wr = 1'b0;
        special_mode = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
    endtask

    task automatic start_once();
        @(negedge clk);
        dly_start = 1'b1;
        @(negedge clk);
        dly_start = 1'b0;
    endtask

    initial begin
        #1_600_000;
        n_checks++;
        n_fail++;
        $display("FAIL R12 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        @(negedge clk);
        check("R1 rdata after reset", reg_rdata, 8'h00);
        check("R1 done after reset", dly_done, 0);
        check("R1 ticks after reset", dly_ticks, 1);

        // decode table, configured in special mode (lock never arms)
        for (int i = 0; i < NV; i++) begin
            reg_write(VECS[i][27:20], 1'b1);
            rom_at_low = VECS[i][19];
            ext_access = VECS[i][18];
            cpu_addr   = VECS[i][17:2];
            #2;
            check($sformatf("R6 ee_sel vec%0d", i), ee_sel, VECS[i][1]);
            check($sformatf("R7/R8/R9/R10 stretch vec%0d", i), stretch_req, VECS[i][0]);
            check($sformatf("R4 rdata vec%0d", i), reg_rdata, VECS[i][27:20] & 8'hFB);
        end
        ext_access = 1'b0;

        // R2/R3/R4 write-once in normal mode
        do_reset();
        reg_write(8'h3B, 1'b0);
        check("R2 first normal write", reg_rdata, 8'h3B);
        reg_write(8'h74, 1'b0);
        check("R2 R3 R4 second normal write", reg_rdata, 8'h30);
        reg_write(8'h9F, 1'b1);
        check("R5 special write over lock", reg_rdata, 8'h9B);
        reg_write(8'h50, 1'b0);
        check("R2 lock still held", reg_rdata, 8'h90);

        // R5 special write does not arm lock
        do_reset();
        reg_write(8'h60, 1'b1);
        check("R5 special load", reg_rdata, 8'h60);
        reg_write(8'h21, 1'b0);
        check("R5 normal write after special", reg_rdata, 8'h21);
        reg_write(8'h41, 1'b0);
        check("R2 lock after first normal", reg_rdata, 8'h21);

        // R12 idle ticks give no done
        tick_once();
        check("R12 idle tick no done", dly_done, 0);

        // R11/R12 each delay code
        for (int c = 0; c < 4; c++) begin
            reg_write(8'(c), 1'b0);
            check($sformatf("R11 ticks code%0d", c), dly_ticks, c + 1);
            start_once();
            for (int t = 1; t <= c + 1; t++) begin
                tick_once();
                check($sformatf("R12 done code%0d tick%0d", c, t), dly_done, (t == c + 1) ? 1 : 0);
            end
            @(negedge clk);
            check($sformatf("R12 done single code%0d", c), dly_done, 0);
        end

        // R13 restart while counting (code 3 -> 4 ticks)
        reg_write(8'h03, 1'b0);
        start_once();
        tick_once();
        tick_once();
        start_once();
        for (int t = 1; t <= 4; t++) begin
            tick_once();
            check($sformatf("R13 restart tick%0d", t), dly_done, (t == 4) ? 1 : 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule